// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the 8-bit status byte of a small microcontroller core. On every cycle in which the ALU reports an operation, it derives the arithmetic flags from the operands and the result that the ALU supplies. Those flags are carry, half-carry, zero and overflow. The block also keeps two power-status bits, which record that the core halted and that the watchdog timed out. These bits change only on the system event strobes for power-up, watchdog-clear, halt and watchdog time-out.

Software can load the four arithmetic flags through a simple write port. The power-status bits cannot be written. When an operation and a write land in the same cycle, the flags that the operation updates take the operation's value. The remaining arithmetic flags take the written value. All outputs come straight from registers, so every effect appears one clock edge after the inputs that cause it.

Top module: `status_flag_reg`

## Requirements
- R1: The status byte `status_o` has the layout bit0 carry, bit1 half-carry, bit2 zero, bit3 overflow, bit4 power-down, bit5 time-out. Bits 7:6 always read 0, and asynchronous reset clears the whole byte.
- R2: An add operation (`op_i`=0, a+b) sets carry on a carry out of bit 7. It sets half-carry on a carry out of bit 3. Each of these flags is cleared otherwise.
- R3: A subtract operation (`op_i`=1, a-b) sets carry when the subtraction needs no borrow (a>=b unsigned). It sets half-carry when the low nibble needs no borrow (a[3:0]>=b[3:0]). Each of these flags is cleared otherwise.
- R4: Add, subtract and logic operations set zero when `res_i` is 0x00 and clear it otherwise.
- R5: Add and subtract operations set overflow when the carry into bit 7 differs from the carry out of bit 7, and clear it otherwise.
- R6: A rotate-through-carry operation (`op_i`=3) loads carry from `rot_c_i` and leaves half-carry, zero and overflow unchanged.
- R7: A logic operation (`op_i`=2) updates only zero and leaves carry, half-carry and overflow unchanged.
- R8: Power-down is cleared by `pwr_up_i` or `wdt_clr_i` and set by `halt_i`. A clearing strobe wins over `halt_i` in the same cycle.
- R9: Time-out is cleared by `pwr_up_i`, `wdt_clr_i` or `halt_i` and set by `wdt_to_i`. A clearing strobe wins over `wdt_to_i` in the same cycle.
- R10: A write (`wr_en_i`) loads `wr_data_i[3:0]` into bits 3:0 and has no effect on bits 5:4.
- R11: When an operation and a write occur in the same cycle, each flag that the operation updates takes the operation's value. Every other arithmetic flag takes the written value.
- R12: With no operation and no write, the arithmetic flags hold their values. With no event strobe, the power bits hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | An ALU operation completes this cycle |
| op_i | input | 2 | Operation class: 0 add, 1 subtract, 2 logic, 3 rotate through carry |
| opa_i | input | 8 | First operand |
| opb_i | input | 8 | Second operand (subtrahend for subtract) |
| res_i | input | 8 | ALU result byte |
| rot_c_i | input | 1 | Bit shifted into carry by a rotate |
| wr_en_i | input | 1 | Write strobe for the arithmetic flags |
| wr_data_i | input | 8 | Write data; bits 3:0 are used |
| pwr_up_i | input | 1 | Power-up event |
| wdt_clr_i | input | 1 | Watchdog-clear event |
| halt_i | input | 1 | Halt event |
| wdt_to_i | input | 1 | Watchdog time-out event |
| status_o | output | 8 | Status byte |

## Verification
Two functions can act on the same flag bits in one cycle: an ALU operation's flag update and a direct write. The bench provokes this by asserting a write together with each operation class. It uses written values that differ from the values the operation would produce. For each bit it then checks whether the value came from the operation (the bits that the class updates) or from the write (the others). The power bits face a similar contest among event strobes, so the bench also fires clearing strobes together with halt and time-out.

// File: rtl/status_pkg.sv
package status_pkg;
  typedef enum logic [1:0] {
    OP_ADD   = 2'd0,
    OP_SUB   = 2'd1,
    OP_LOGIC = 2'd2,
    OP_ROT   = 2'd3
  } op_e;

  localparam int unsigned F_C  = 0;
  localparam int unsigned F_AC = 1;
  localparam int unsigned F_Z  = 2;
  localparam int unsigned F_OV = 3;
  localparam int unsigned F_PD = 4;
  localparam int unsigned F_TO = 5;
  localparam int unsigned NFLAG = 4;
endpackage

// File: rtl/status_arith_flags.sv
module status_arith_flags
  import status_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic             op_valid_i,
  input  logic [1:0]       op_i,
  input  logic [DW-1:0]    opa_i,
  input  logic [DW-1:0]    opb_i,
  input  logic [DW-1:0]    res_i,
  input  logic             rot_c_i,
  output logic [NFLAG-1:0] upd_mask_o,
  output logic [NFLAG-1:0] upd_val_o
);
  localparam int unsigned NIB = DW / 2;

  op_e           op;
  logic          cin;
  logic [DW-1:0] b_eff;
  logic [NIB:0]  lo_sum;
  logic [DW-1:0] msb_in_sum;
  logic [DW:0]   full_sum;

  assign op = op_e'(op_i);

  // subtract as a + ~b + 1: carry out means no borrow
  always_comb begin
    cin        = (op == OP_SUB);
    b_eff      = (op == OP_SUB) ? ~opb_i : opb_i;
    lo_sum     = {1'b0, opa_i[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, cin};
    msb_in_sum = {1'b0, opa_i[DW-2:0]} + {1'b0, b_eff[DW-2:0]} + {{(DW-1){1'b0}}, cin};
    full_sum   = {1'b0, opa_i} + {1'b0, b_eff} + {{DW{1'b0}}, cin};
  end

  always_comb begin
    upd_mask_o = '0;
    upd_val_o  = '0;
    if (op_valid_i) begin
      unique case (op)
        OP_ADD, OP_SUB: begin
          upd_mask_o       = '1;
          upd_val_o[F_C]   = full_sum[DW];
          upd_val_o[F_AC]  = lo_sum[NIB];
          upd_val_o[F_Z]   = (res_i == '0);
          upd_val_o[F_OV]  = msb_in_sum[DW-1] ^ full_sum[DW];
        end
        OP_LOGIC: begin
          upd_mask_o[F_Z]  = 1'b1;
          upd_val_o[F_Z]   = (res_i == '0);
        end
        OP_ROT: begin
          upd_mask_o[F_C]  = 1'b1;
          upd_val_o[F_C]   = rot_c_i;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/status_pwr_bits.sv
module status_pwr_bits (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_up_i,
  input  logic wdt_clr_i,
  input  logic halt_i,
  input  logic wdt_to_i,
  output logic pd_o,
  output logic to_o
);
  logic clr_both;
  assign clr_both = pwr_up_i | wdt_clr_i;

  // clearing events dominate setting events
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_o <= 1'b0;
      to_o <= 1'b0;
    end else begin
      if (clr_both)      pd_o <= 1'b0;
      else if (halt_i)   pd_o <= 1'b1;
      if (clr_both || halt_i) to_o <= 1'b0;
      else if (wdt_to_i)      to_o <= 1'b1;
    end
  end
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
  import status_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          op_valid_i,
  input  logic [1:0]    op_i,
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  input  logic [DW-1:0] res_i,
  input  logic          rot_c_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          pwr_up_i,
  input  logic          wdt_clr_i,
  input  logic          halt_i,
  input  logic          wdt_to_i,
  output logic [DW-1:0] status_o
);
  logic [NFLAG-1:0] upd_mask, upd_val, af_q, af_d;
  logic             pd_q, to_q;

  status_arith_flags #(.DW(DW)) u_arith (
    .op_valid_i (op_valid_i),
    .op_i       (op_i),
    .opa_i      (opa_i),
    .opb_i      (opb_i),
    .res_i      (res_i),
    .rot_c_i    (rot_c_i),
    .upd_mask_o (upd_mask),
    .upd_val_o  (upd_val)
  );

  status_pwr_bits u_pwr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pwr_up_i  (pwr_up_i),
    .wdt_clr_i (wdt_clr_i),
    .halt_i    (halt_i),
    .wdt_to_i  (wdt_to_i),
    .pd_o      (pd_q),
    .to_o      (to_q)
  );

  // per-bit priority: op update, then write, then hold
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_comb begin
      if (upd_mask[i])  af_d[i] = upd_val[i];
      else if (wr_en_i) af_d[i] = wr_data_i[i];
      else              af_d[i] = af_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) af_q <= '0;
    else         af_q <= af_d;
  end

  always_comb begin
    status_o       = '0;
    status_o[3:0]  = af_q;
    status_o[F_PD] = pd_q;
    status_o[F_TO] = to_q;
  end
endmodule

// File: rtl/status_flag_reg_chk.sv
module status_flag_reg_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          op_valid_i,
  input logic [1:0]    op_i,
  input logic          rot_c_i,
  input logic          wr_en_i,
  input logic          pwr_up_i,
  input logic          wdt_clr_i,
  input logic          halt_i,
  input logic          wdt_to_i,
  input logic [DW-1:0] status_o
);
  logic clr_ev;
  assign clr_ev = pwr_up_i | wdt_clr_i;

  p_upper_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[DW-1:6] == '0);

  p_rot_carry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 2'd3) |=> status_o[0] == $past(rot_c_i));

  p_rot_keeps_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 2'd3 && !wr_en_i) |=> $stable(status_o[3:1]));

  p_logic_keeps_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 2'd2 && !wr_en_i) |=> ($stable(status_o[1:0]) && $stable(status_o[3])));

  p_pd_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ev |=> !status_o[4]);

  p_pd_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !clr_ev) |=> status_o[4]);

  p_to_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ev || halt_i) |=> !status_o[5]);

  p_to_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_to_i && !clr_ev && !halt_i) |=> status_o[5]);

  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_valid_i && !wr_en_i) |=> $stable(status_o[3:0]));

  p_pwr_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_ev && !halt_i && !wdt_to_i) |=> $stable(status_o[5:4]));
endmodule

bind status_flag_reg status_flag_reg_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_valid_i (op_valid_i),
  .op_i       (op_i),
  .rot_c_i    (rot_c_i),
  .wr_en_i    (wr_en_i),
  .pwr_up_i   (pwr_up_i),
  .wdt_clr_i  (wdt_clr_i),
  .halt_i     (halt_i),
  .wdt_to_i   (wdt_to_i),
  .status_o   (status_o)
);

// File: tb/status_flag_reg_tb_top.sv
module status_flag_reg_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       op_valid_i = 1'b0;
  logic [1:0] op_i = '0;
  logic [7:0] opa_i = '0, opb_i = '0, res_i = '0, wr_data_i = '0;
  logic       rot_c_i = 1'b0, wr_en_i = 1'b0;
  logic       pwr_up_i = 1'b0, wdt_clr_i = 1'b0, halt_i = 1'b0, wdt_to_i = 1'b0;
  logic [7:0] status_o;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] exp_s = '0;

  always #5 clk_i = ~clk_i;

  status_flag_reg dut_i (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: status actual %02h expected %02h", req, act, exp);
    end
  endtask

  // expected arithmetic flags, written from the requirement text
  function automatic logic [3:0] model(input logic [1:0] op, input logic [7:0] a, b, r,
                                       input logic rc, input logic [3:0] old,
                                       input logic wr, input logic [3:0] wd);
    logic [3:0] base, m, v;
    int sa, sb, ss;
    base = wr ? wd : old;
    m = 4'b0000; v = 4'b0000;
    sa = $signed(a); sb = $signed(b);
    case (op)
      2'd0: begin
        m = 4'b1111;
        v[0] = (int'(a) + int'(b)) > 255;
        v[1] = (int'(a[3:0]) + int'(b[3:0])) > 15;
        ss = sa + sb;
        v[3] = (ss > 127) || (ss < -128);
      end
      2'd1: begin
        m = 4'b1111;
        v[0] = a >= b;
        v[1] = a[3:0] >= b[3:0];
        ss = sa - sb;
        v[3] = (ss > 127) || (ss < -128);
      end
      2'd2: m = 4'b0100;
      default: begin m = 4'b0001; v[0] = rc; end
    endcase
    v[2] = (r == 8'h00);
    return (m & v) | (~m & base);
  endfunction

  task automatic step_op(input string req, input logic [1:0] op, input logic [7:0] a, b,
                         input logic rc, input logic wr, input logic [3:0] wd);
    logic [7:0] r;
    case (op)
      2'd0: r = a + b;
      2'd1: r = a - b;
      2'd2: r = a & b;
      default: r = {a[6:0], rc};
    endcase
    @(negedge clk_i);
    op_valid_i = 1'b1; op_i = op; opa_i = a; opb_i = b; res_i = r; rot_c_i = rc;
    wr_en_i = wr; wr_data_i = {4'hA, wd};
    exp_s[3:0] = model(op, a, b, r, rc, exp_s[3:0], wr, wd);
    @(posedge clk_i); #1;
    op_valid_i = 1'b0; wr_en_i = 1'b0;
    check(req, status_o, exp_s);
  endtask

  task automatic step_wr(input string req, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_data_i = d;
    exp_s[3:0] = d[3:0];
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
    check(req, status_o, exp_s);
  endtask

  task automatic step_ev(input string req, input logic pu, input logic wc,
                         input logic h, input logic t);
    @(negedge clk_i);
    pwr_up_i = pu; wdt_clr_i = wc; halt_i = h; wdt_to_i = t;
    if (pu || wc)  exp_s[4] = 1'b0; else if (h) exp_s[4] = 1'b1;
    if (pu || wc || h) exp_s[5] = 1'b0; else if (t) exp_s[5] = 1'b1;
    @(posedge clk_i); #1;
    {pwr_up_i, wdt_clr_i, halt_i, wdt_to_i} = '0;
    check(req, status_o, exp_s);
  endtask

  task automatic t_reset();
    #1 check("R1 reset", status_o, 8'h00);
    repeat (2) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1 check("R1 after reset", status_o, 8'h00);
  endtask

  task automatic t_add();
    step_op("R2 add nibble carry", 2'd0, 8'h0F, 8'h01, 1'b0, 1'b0, 4'h0);
    step_op("R2 R4 add wrap zero", 2'd0, 8'hFF, 8'h01, 1'b0, 1'b0, 4'h0);
    step_op("R5 add pos overflow", 2'd0, 8'h7F, 8'h01, 1'b0, 1'b0, 4'h0);
    step_op("R5 add neg overflow", 2'd0, 8'h80, 8'h80, 1'b0, 1'b0, 4'h0);
    step_op("R2 add plain", 2'd0, 8'h12, 8'h21, 1'b0, 1'b0, 4'h0);
  endtask

  task automatic t_sub();
    step_op("R3 sub no borrow", 2'd1, 8'h05, 8'h03, 1'b0, 1'b0, 4'h0);
    step_op("R3 sub borrow", 2'd1, 8'h03, 8'h05, 1'b0, 1'b0, 4'h0);
    step_op("R3 sub nibble borrow", 2'd1, 8'h10, 8'h01, 1'b0, 1'b0, 4'h0);
    step_op("R3 R4 sub equal", 2'd1, 8'h5A, 8'h5A, 1'b0, 1'b0, 4'h0);
    step_op("R5 sub overflow", 2'd1, 8'h80, 8'h01, 1'b0, 1'b0, 4'h0);
  endtask

  task automatic t_logic_rot();
    step_wr("R10 preset", 8'h0B);
    step_op("R7 R4 logic zero", 2'd2, 8'hF0, 8'h0F, 1'b0, 1'b0, 4'h0);
    step_op("R7 logic nonzero", 2'd2, 8'hF0, 8'h3C, 1'b0, 1'b0, 4'h0);
    step_op("R6 rotate in 0", 2'd3, 8'h81, 8'h00, 1'b0, 1'b0, 4'h0);
    step_op("R6 rotate in 1", 2'd3, 8'h01, 8'h00, 1'b1, 1'b0, 4'h0);
  endtask

  task automatic t_power();
    step_ev("R8 halt", 1'b0, 1'b0, 1'b1, 1'b0);
    step_ev("R9 timeout", 1'b0, 1'b0, 1'b0, 1'b1);
    step_ev("R8 R9 wdt clear", 1'b0, 1'b1, 1'b0, 1'b0);
    step_ev("R9 timeout again", 1'b0, 1'b0, 1'b0, 1'b1);
    step_ev("R9 halt clears timeout", 1'b0, 1'b0, 1'b1, 1'b1);
    step_ev("R8 R9 power up wins", 1'b1, 1'b0, 1'b1, 1'b1);
    step_ev("R9 timeout set", 1'b0, 1'b0, 1'b0, 1'b1);
    step_wr("R10 write leaves power bits", 8'hFF);
    step_wr("R10 write clears", 8'h30);
    repeat (3) @(posedge clk_i);
    #1 check("R12 hold", status_o, exp_s);
  endtask

  task automatic t_collide();
    step_op("R11 add vs write", 2'd0, 8'h01, 8'h01, 1'b0, 1'b1, 4'hF);
    step_op("R11 logic vs write", 2'd2, 8'h0F, 8'h0F, 1'b0, 1'b1, 4'hF);
    step_op("R11 logic zero vs write", 2'd2, 8'h00, 8'hFF, 1'b0, 1'b1, 4'h0);
    step_op("R11 rotate vs write", 2'd3, 8'h00, 8'h00, 1'b0, 1'b1, 4'hF);
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_logic_rot();
    t_power();
    t_collide();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    #200us;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule